// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Stage

This block sits between a bank of interrupt sources and one processor. It keeps a single pending slot and decides, offer by offer, whether a source gets that slot or is bounced back. It also holds a 32-bit presentation word, a pending-priority byte and an inter-processor-interrupt (IPI) priority byte. Priorities are 8-bit values in which a smaller number wins. A source that loses, or that is pushed out of the slot by a better one, leaves on a reject pulse so the source layer can offer it again later. Nothing is queued here.

The processor drives a single-cycle command port with four operations. It can set its own priority threshold and set the IPI priority. It can take (accept) the pending interrupt, which returns the presentation word. It can signal end-of-interrupt, which restores a threshold and forwards the finished source number. When the slot becomes free while the threshold is loosened, the block asks the source layer to resend rejected sources. Before it does so, it lets a waiting IPI take the slot. Source offers use a valid/ready handshake. An offer is held off (ready low) in any cycle that carries a command, so the command is always served first. The offerer must then hold its offer stable until ready is high.

Top module: `intr_present_ctrl`

## Requirements
- R1: After reset the interrupt line is low, the presentation word reads as zero on accept, and the IPI priority is 0xFF. At 0xFF the IPI never fires, even when the threshold is raised to 0xFF.
- R2: An accepted offer (offer_valid and offer_ready high at a clock edge) is bounced on the reject port in either of two cases. The first is that its priority is greater than or equal to the threshold. The second is that a source is already pending with a priority less than or equal to the offered one.
- R3: An offer that wins while another source is pending sends the old source number to the reject port. The new number and priority take the slot and the interrupt line is high. The line is high exactly while the slot holds a nonzero source number.
- R4: Command op 1 stores cmd_data[7:0] as the IPI priority. If that value is below the threshold, the IPI takes the slot with source number IPI_SRC (default 2), rejecting any pending source. The exception is a pending source whose priority is less than or equal to the new value: it stays and nothing is rejected.
- R5: Command op 0 writes cmd_data[7:0] as the threshold. If the new value is below the old one and a source is pending whose priority is greater than or equal to the new value, the slot is cleared, the line drops and that source is rejected.
- R6: If op 0 writes a value greater than or equal to the old threshold while the slot is empty, a resend pulse is issued. In the same step, an IPI whose priority is below the new threshold takes the slot.
- R7: Command op 2 (accept) returns {threshold[31:24], source[23:0]} on rd_data with rd_valid. It lowers the line, then sets the threshold to the pending priority and empties the slot.
- R8: Command op 3 (end-of-interrupt) pulses eoi_valid with cmd_data[23:0] and sets the threshold to cmd_data[31:24]. If the slot is empty it performs the R6 resend step using that new threshold.
- R9: All outputs are registered and change one cycle after the edge that takes the command or offer. The reject, eoi, resend and read pulses last exactly one cycle.
- R10: offer_ready is low in any cycle where cmd_valid is high. A held offer is served in the first following cycle without a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | A source offer is present |
| offer_ready | output | 1 | Offer is taken at this edge |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 2 | 0 threshold, 1 IPI priority, 2 accept, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| irq_out | output | 1 | Interrupt line to the processor |
| rd_valid | output | 1 | Accept result pulse |
| rd_data | output | 32 | Presentation word returned by accept |
| rej_valid | output | 1 | Reject pulse to the source layer |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source layer |
| eoi_src | output | 24 | Finished source number |
| resend_req | output | 1 | Resend request pulse to the source layer |

## Verification
Offers are driven at equal, better and worse priority than both the threshold and the pending source. This separates a strict comparison from a non-strict one, and a bounced newcomer from a displaced incumbent. IPI writes are tried both below and above the pending priority, to tell a held slot from a pre-empted one. Threshold writes that tie the pending priority, and end-of-interrupt with an armed and a disarmed IPI, show whether the resend step looks at the freshly written threshold. A command and an offer driven in the same cycle show the command-first ordering.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {
    OP_SET_THRESH = 2'd0,
    OP_SET_IPI    = 2'd1,
    OP_ACCEPT     = 2'd2,
    OP_EOI        = 2'd3
  } ipc_op_e;
endpackage

// File: rtl/ipc_offer_eval.sv
// Decides the fate of one incoming source offer against the current slot.
module ipc_offer_eval #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] thresh,
  input  logic [SRC_W-1:0]  slot_src,
  input  logic [PRIO_W-1:0] slot_prio,
  input  logic [SRC_W-1:0]  new_src,
  input  logic [PRIO_W-1:0] new_prio,
  output logic              take,
  output logic              bounce,
  output logic [SRC_W-1:0]  bounce_src
);
  logic occupied;
  logic loses;

  always_comb begin
    occupied   = (slot_src != '0);
    loses      = (new_prio >= thresh) || (occupied && (slot_prio <= new_prio));
    take       = !loses;
    bounce     = loses || occupied;
    bounce_src = loses ? new_src : slot_src;
  end
endmodule

// File: rtl/ipc_ipi_eval.sv
// Evaluates whether the IPI should claim the slot under a given threshold.
module ipc_ipi_eval #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] thresh,
  input  logic [PRIO_W-1:0] ipi_prio,
  input  logic [SRC_W-1:0]  slot_src,
  input  logic [PRIO_W-1:0] slot_prio,
  output logic              load,
  output logic              evict
);
  logic armed;
  logic held;

  always_comb begin
    armed = (ipi_prio < thresh);
    held  = (slot_src != '0) && (slot_prio <= ipi_prio);
    load  = armed && !held;
    evict = load && (slot_src != '0);
  end
endmodule

// File: rtl/intr_present_ctrl.sv
module intr_present_ctrl #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8,
  parameter logic [SRC_W-1:0] IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    offer_valid,
  output logic                    offer_ready,
  input  logic [SRC_W-1:0]        offer_src,
  input  logic [PRIO_W-1:0]       offer_prio,
  input  logic                    cmd_valid,
  input  logic [1:0]              cmd_op,
  input  logic [PRIO_W+SRC_W-1:0] cmd_data,
  output logic                    irq_out,
  output logic                    rd_valid,
  output logic [PRIO_W+SRC_W-1:0] rd_data,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src,
  output logic                    resend_req
);
  import ipc_pkg::*;

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_OFF = '1;

  // architectural state
  logic [PRIO_W-1:0] thresh_q, thresh_d;
  logic [SRC_W-1:0]  slot_q, slot_d;
  logic [PRIO_W-1:0] pend_q, pend_d;
  logic [PRIO_W-1:0] ipi_q, ipi_d;
  logic              irq_q, irq_d;

  // registered pulses
  logic              rd_v_d, rej_v_d, eoi_v_d, resend_d;
  logic [WORD_W-1:0] rd_data_d;
  logic [SRC_W-1:0]  rej_src_d, eoi_src_d;

  // operand decode
  logic [PRIO_W-1:0] op_prio;
  logic [PRIO_W-1:0] eoi_thresh;
  logic [SRC_W-1:0]  eoi_num;
  logic [PRIO_W-1:0] thresh_eff;
  logic [PRIO_W-1:0] ipi_eff;
  logic              offer_fire;

  assign op_prio     = cmd_data[PRIO_W-1:0];
  assign eoi_thresh  = cmd_data[WORD_W-1:SRC_W];
  assign eoi_num     = cmd_data[SRC_W-1:0];
  assign offer_ready = !cmd_valid;
  assign offer_fire  = offer_valid && offer_ready;

  always_comb begin
    thresh_eff = thresh_q;
    ipi_eff    = ipi_q;
    if (cmd_valid) begin
      case (cmd_op)
        OP_SET_THRESH: thresh_eff = op_prio;
        OP_EOI:        thresh_eff = eoi_thresh;
        OP_SET_IPI:    ipi_eff    = op_prio;
        default:       thresh_eff = thresh_q;
      endcase
    end
  end

  logic ipi_load, ipi_evict;

  ipc_ipi_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipi (
    .thresh    (thresh_eff),
    .ipi_prio  (ipi_eff),
    .slot_src  (slot_q),
    .slot_prio (pend_q),
    .load      (ipi_load),
    .evict     (ipi_evict)
  );

  logic             off_take, off_bounce;
  logic [SRC_W-1:0] off_bounce_src;

  ipc_offer_eval #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_offer (
    .thresh     (thresh_q),
    .slot_src   (slot_q),
    .slot_prio  (pend_q),
    .new_src    (offer_src),
    .new_prio   (offer_prio),
    .take       (off_take),
    .bounce     (off_bounce),
    .bounce_src (off_bounce_src)
  );

  always_comb begin
    thresh_d  = thresh_q;
    slot_d    = slot_q;
    pend_d    = pend_q;
    ipi_d     = ipi_q;
    irq_d     = irq_q;
    rd_v_d    = 1'b0;
    rd_data_d = '0;
    rej_v_d   = 1'b0;
    rej_src_d = '0;
    eoi_v_d   = 1'b0;
    eoi_src_d = '0;
    resend_d  = 1'b0;

    if (cmd_valid) begin
      case (cmd_op)
        OP_SET_THRESH: begin
          thresh_d = op_prio;
          if (op_prio < thresh_q) begin
            if ((slot_q != '0) && (op_prio <= pend_q)) begin
              slot_d    = '0;
              irq_d     = 1'b0;
              rej_v_d   = 1'b1;
              rej_src_d = slot_q;
            end
          end else if (slot_q == '0) begin
            resend_d = 1'b1;
            if (ipi_load) begin
              slot_d = IPI_SRC;
              pend_d = ipi_q;
              irq_d  = 1'b1;
            end
          end
        end
        OP_SET_IPI: begin
          ipi_d = op_prio;
          if (ipi_load) begin
            if (ipi_evict) begin
              rej_v_d   = 1'b1;
              rej_src_d = slot_q;
            end
            slot_d = IPI_SRC;
            pend_d = op_prio;
            irq_d  = 1'b1;
          end
        end
        OP_ACCEPT: begin
          rd_v_d    = 1'b1;
          rd_data_d = {thresh_q, slot_q};
          irq_d     = 1'b0;
          thresh_d  = pend_q;
          slot_d    = '0;
        end
        default: begin
          eoi_v_d   = 1'b1;
          eoi_src_d = eoi_num;
          thresh_d  = eoi_thresh;
          if (slot_q == '0) begin
            resend_d = 1'b1;
            if (ipi_load) begin
              slot_d = IPI_SRC;
              pend_d = ipi_q;
              irq_d  = 1'b1;
            end
          end
        end
      endcase
    end else if (offer_fire) begin
      if (off_bounce) begin
        rej_v_d   = 1'b1;
        rej_src_d = off_bounce_src;
      end
      if (off_take) begin
        slot_d = offer_src;
        pend_d = offer_prio;
        irq_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thresh_q   <= '0;
      slot_q     <= '0;
      pend_q     <= '0;
      ipi_q      <= PRIO_OFF;
      irq_q      <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rej_valid  <= 1'b0;
      rej_src    <= '0;
      eoi_valid  <= 1'b0;
      eoi_src    <= '0;
      resend_req <= 1'b0;
    end else begin
      thresh_q   <= thresh_d;
      slot_q     <= slot_d;
      pend_q     <= pend_d;
      ipi_q      <= ipi_d;
      irq_q      <= irq_d;
      rd_valid   <= rd_v_d;
      rd_data    <= rd_data_d;
      rej_valid  <= rej_v_d;
      rej_src    <= rej_src_d;
      eoi_valid  <= eoi_v_d;
      eoi_src    <= eoi_src_d;
      resend_req <= resend_d;
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int SRC_W  = 24,
  parameter int PRIO_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    offer_valid,
  input logic                    offer_ready,
  input logic [SRC_W-1:0]        offer_src,
  input logic [PRIO_W-1:0]       offer_prio,
  input logic                    cmd_valid,
  input logic [1:0]              cmd_op,
  input logic [PRIO_W+SRC_W-1:0] cmd_data,
  input logic                    irq_out,
  input logic                    rd_valid,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic [PRIO_W-1:0]       thresh_q,
  input logic [SRC_W-1:0]        slot_q
);
  a_r2_offer_bounced: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && offer_ready && (offer_prio >= thresh_q))
      |=> (rej_valid && (rej_src == $past(offer_src))));

  a_r3_line_tracks_slot: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (slot_q != '0));

  a_r7_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 2'd2)) |=> (rd_valid && !irq_out && (slot_q == '0)));

  a_r8_eoi_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 2'd3))
      |=> (eoi_valid && (eoi_src == $past(cmd_data[SRC_W-1:0]))));

  a_r9_read_only_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && (cmd_op == 2'd2)));
endmodule

bind intr_present_ctrl ipc_checker #(.SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ipc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .offer_valid (offer_valid),
  .offer_ready (offer_ready),
  .offer_src   (offer_src),
  .offer_prio  (offer_prio),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_data    (cmd_data),
  .irq_out     (irq_out),
  .rd_valid    (rd_valid),
  .rej_valid   (rej_valid),
  .rej_src     (rej_src),
  .eoi_valid   (eoi_valid),
  .eoi_src     (eoi_src),
  .thresh_q    (thresh_q),
  .slot_q      (slot_q)
);

// File: tb/tb_intr_present_ctrl.sv
`timescale 1ns/1ps
module tb_intr_present_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        offer_valid;
  logic        offer_ready;
  logic [23:0] offer_src;
  logic [7:0]  offer_prio;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_data;
  logic        irq_out;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rej_valid;
  logic [23:0] rej_src;
  logic        eoi_valid;
  logic [23:0] eoi_src;
  logic        resend_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  intr_present_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .offer_valid(offer_valid), .offer_ready(offer_ready),
    .offer_src(offer_src), .offer_prio(offer_prio),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .irq_out(irq_out), .rd_valid(rd_valid), .rd_data(rd_data),
    .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drive one command; returns 1ns after the edge that takes it
  task automatic cmd(logic [1:0] op, logic [31:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = data;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic offer(logic [23:0] src, logic [7:0] prio);
    @(negedge clk);
    offer_valid = 1'b1; offer_src = src; offer_prio = prio;
    @(posedge clk); #1;
    offer_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "irq after reset", 32'(irq_out), 32'd0);
    check("R1", "reject after reset", 32'(rej_valid), 32'd0);
    cmd(2'd2, 32'd0);
    check("R1", "accept word after reset", rd_data, 32'd0);
    check("R7", "accept pulse", 32'(rd_valid), 32'd1);
    cmd(2'd0, 32'hFF);
    check("R6", "resend on raise with empty slot", 32'(resend_req), 32'd1);
    check("R1", "ipi inactive at reset", 32'(irq_out), 32'd0);
  endtask

  task automatic t_offers();
    offer(24'h20, 8'd5);
    check("R3", "first offer taken", 32'(irq_out), 32'd1);
    check("R3", "no reject on empty slot", 32'(rej_valid), 32'd0);
    offer(24'h21, 8'd5);
    check("R2", "equal prio bounced valid", 32'(rej_valid), 32'd1);
    check("R2", "equal prio bounced src", 32'(rej_src), 32'h21);
    offer(24'h22, 8'd3);
    check("R3", "incumbent displaced", 32'(rej_src), 32'h20);
    check("R3", "line stays up", 32'(irq_out), 32'd1);
    @(posedge clk); #1;
    check("R9", "reject pulse one cycle", 32'(rej_valid), 32'd0);
    offer(24'h23, 8'hFF);
    check("R2", "prio at threshold bounced", 32'(rej_src), 32'h23);
    cmd(2'd2, 32'd0);
    check("R7", "accept word", rd_data, 32'hFF00_0022);
    check("R7", "line dropped", 32'(irq_out), 32'd0);
    cmd(2'd2, 32'd0);
    check("R7", "threshold reloaded from pending", rd_data, 32'h0300_0000);
  endtask

  task automatic t_eoi();
    cmd(2'd3, 32'hFF00_0022);
    check("R8", "eoi pulse", 32'(eoi_valid), 32'd1);
    check("R8", "eoi source", 32'(eoi_src), 32'h22);
    check("R8", "resend with empty slot", 32'(resend_req), 32'd1);
    @(posedge clk); #1;
    check("R9", "eoi pulse one cycle", 32'(eoi_valid), 32'd0);
    cmd(2'd2, 32'd0);
    check("R8", "threshold restored", rd_data, 32'hFF00_0000);
    cmd(2'd3, 32'hFF00_0000);
  endtask

  task automatic t_ipi();
    offer(24'h30, 8'd4);
    cmd(2'd1, 32'd6);
    check("R4", "better pending source keeps slot", 32'(rej_valid), 32'd0);
    check("R4", "line still up", 32'(irq_out), 32'd1);
    cmd(2'd1, 32'd2);
    check("R4", "ipi evicts pending", 32'(rej_src), 32'h30);
    check("R4", "ipi evict pulse", 32'(rej_valid), 32'd1);
    cmd(2'd2, 32'd0);
    check("R4", "ipi presented with its number", rd_data, 32'hFF00_0002);
    cmd(2'd3, 32'hFF00_0002);
    check("R6", "resend pulse on eoi", 32'(resend_req), 32'd1);
    check("R6", "armed ipi re-presented", 32'(irq_out), 32'd1);
    cmd(2'd2, 32'd0);
    check("R6", "re-presented ipi word", rd_data, 32'hFF00_0002);
    cmd(2'd1, 32'hFF);
    cmd(2'd3, 32'hFF00_0002);
    check("R8", "disarmed ipi stays quiet", 32'(irq_out), 32'd0);
  endtask

  task automatic t_thresh_lower();
    offer(24'h40, 8'd8);
    cmd(2'd0, 32'd9);
    check("R5", "better pending kept", 32'(irq_out), 32'd1);
    check("R5", "no reject when kept", 32'(rej_valid), 32'd0);
    cmd(2'd0, 32'd8);
    check("R5", "tie clears slot", 32'(irq_out), 32'd0);
    check("R5", "tie rejects source", 32'(rej_src), 32'h40);
    cmd(2'd2, 32'd0);
    check("R5", "slot empty after clear", rd_data, 32'h0800_0000);
  endtask

  task automatic t_order();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_data = 32'hFF;
    offer_valid = 1'b1; offer_src = 24'h50; offer_prio = 8'd1;
    #1;
    check("R10", "ready low with command", 32'(offer_ready), 32'd0);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    #1;
    check("R10", "ready back after command", 32'(offer_ready), 32'd1);
    check("R10", "offer not yet taken", 32'(irq_out), 32'd0);
    check("R6", "command served first", 32'(resend_req), 32'd1);
    @(posedge clk); #1;
    offer_valid = 1'b0;
    check("R10", "held offer taken next", 32'(irq_out), 32'd1);
    cmd(2'd2, 32'd0);
    check("R10", "held offer word", rd_data, 32'hFF00_0050);
  endtask

  initial begin
    rst_n = 1'b0; offer_valid = 1'b0; offer_src = '0; offer_prio = '0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_offers();
    t_eoi();
    t_ipi();
    t_thresh_lower();
    t_order();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule